// File: doc/BRIEF.md
# Sequenced-Kick Watchdog Timer with Maskable Interrupt Status

This block is a watchdog timer controlled through a small synchronous register port. Software arms it by writing the value 11 into the two-bit mode field of the control register. From then on, software must restart the timer before a fixed period runs out. A restart counts only after two control writes that follow a fixed pattern. If the period elapses without a completed restart, the block emits a reset pulse one clock wide, records an overflow event and disarms itself.

Events are collected in a small interrupt status vector. Bit 0 is the watchdog overflow, and the remaining bits are taken from external event pulses. Each bit passes through a mask in which a 1 hides the bit. A hidden event is not lost: it stays pending internally and shows up as soon as its mask bit is cleared. Reading the status register returns the visible bits and clears only those bits. The interrupt output is high whenever any visible bit is pending.

The period is the product of a prescaler length in clock cycles (`CLK_KHZ`, the number of cycles in one millisecond) and a millisecond count (`PERIOD_MS`, default 128).

Top module: `seqwdt_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the mask register (address 2) reads 0xFF, the status register (address 1) reads 0x00, and `irq_o` and `wdt_rst_o` are low.
- R2: The timer is armed only by a write to address 0 whose bits [1:0] are 11 while the timer is disarmed. If it is never armed, no reset pulse ever occurs.
- R3: Let N = CLK_KHZ*PERIOD_MS. If no restart occurs after arming, `wdt_rst_o` is high during the cycle that follows the N-th rising edge after the edge that sampled the arming write. Status bit 0 is set at that same edge.
- R4: A restart is two writes to address 0, both with bits [1:0] = 11. The first write has bit 2 = 1 and bit 3 = 0. The second write has bit 2 = 0 and bit 3 = 1. Accesses to other addresses may come between them. The full period restarts from the edge that samples the second write.
- R5: A control write that breaks the order does not restart the timer and clears the sequence. Examples are a second-step write with no first step before it, or any other control value written between the two steps. Expiry then stays timed from the last arm or restart.
- R6: The reset pulse lasts exactly one clock. After an expiry the timer stays disarmed until it is armed again. A control write with bits [1:0] other than 11 disarms the timer.
- R7: Status bit 0 is the overflow, and status bits 1 to NSRC-1 come from `evt_i` pulses. A mask bit of 1 (mask register bit i hides status bit i) makes the status bit read as 0 and keeps it out of `irq_o`.
- R8: A masked pending bit stays latched. Once its mask bit is written to 0, it reads as 1 and drives `irq_o`.
- R9: Reading address 1 clears exactly the bits it returned. Masked pending bits survive the read. A new event at the same edge as a clearing read stays set.
- R10: Read data appears on `reg_rdata_o` in the cycle after the edge that samples `reg_rd_i`. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 mask |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| evt_i | input | NSRC-1 | External event pulses into status bits 1 and up |
| irq_o | output | 1 | High while any unmasked pending bit is set |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Read data is due one edge after the read strobe. Event and mask effects on `irq_o` are visible in the cycle after the sampling edge, because the output is a combinational OR of registered state. Expiry is due exactly N edges after the edge that sampled the arming write or the second kick write. The bench keeps a free-running count of rising edges and takes every sample at a falling edge. It records the count at the return of each write and checks `wdt_rst_o` at count N-1 (low), N (high) and N+1 (low) relative to that write. A separate pulse counter shows that no early pulse was missed, and long quiet windows prove that no pulse occurs while disarmed.

// File: rtl/seqwdt_pkg.sv
package seqwdt_pkg;

    localparam int DW = 8;
    localparam int AW = 2;

    typedef enum logic [AW-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_MASK = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [3:0] spare;
        logic       kick_b;
        logic       kick_a;
        logic [1:0] mode;
    } ctrl_t;

    localparam logic [1:0] MODE_WDT = 2'b11;

    typedef enum logic {
        KS_IDLE = 1'b0,
        KS_HALF = 1'b1
    } kick_st_e;

    typedef enum logic [1:0] {
        KW_OTHER  = 2'd0,
        KW_FIRST  = 2'd1,
        KW_SECOND = 2'd2
    } kick_word_e;

    function automatic kick_word_e classify_kick(input logic a, input logic b);
        if (a && !b)      return KW_FIRST;
        else if (!a && b) return KW_SECOND;
        else              return KW_OTHER;
    endfunction

endpackage

// File: rtl/seqwdt_kick.sv
module seqwdt_kick
    import seqwdt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic armed_i,
    input  logic ctrl_wr_i,
    input  logic kick_a_i,
    input  logic kick_b_i,
    output logic restart_o
);

    kick_st_e   st_q;
    kick_word_e word;

    assign word      = classify_kick(kick_a_i, kick_b_i);
    assign restart_o = armed_i && ctrl_wr_i && (st_q == KS_HALF) && (word == KW_SECOND);

    always_ff @(posedge clk_i) begin
        if (rst_i || !armed_i) begin
            st_q <= KS_IDLE;
        end else if (ctrl_wr_i) begin
            st_q <= (word == KW_FIRST) ? KS_HALF : KS_IDLE;
        end
    end

endmodule

// File: rtl/seqwdt_timer.sv
module seqwdt_timer #(
    parameter int DIV    = 100000,
    parameter int PERIOD = 128
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic arm_req_i,
    input  logic disarm_req_i,
    input  logic restart_i,
    output logic armed_o,
    output logic fire_o,
    output logic pulse_o
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD - 1);

    logic [PW-1:0] pre_q;
    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          pulse_q;
    logic          start;
    logic          tick;

    assign start  = (!armed_q && arm_req_i) || restart_i;
    assign tick   = armed_q && (pre_q == PRE_LAST);
    assign fire_o = tick && (cnt_q == CNT_LAST) && !disarm_req_i && !start;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            armed_q <= 1'b0;
            pre_q   <= '0;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire_o;
            if (disarm_req_i) begin
                armed_q <= 1'b0;
                pre_q   <= '0;
                cnt_q   <= '0;
            end else if (start) begin
                armed_q <= 1'b1;
                pre_q   <= '0;
                cnt_q   <= '0;
            end else if (armed_q) begin
                if (tick) begin
                    pre_q <= '0;
                    if (cnt_q == CNT_LAST) begin
                        armed_q <= 1'b0;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    assign armed_o = armed_q;
    assign pulse_o = pulse_q;

endmodule

// File: rtl/seqwdt_irq.sv
module seqwdt_irq #(
    parameter int NSRC = 4
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] mask_i,
    input  logic            rd_clr_i,
    output logic [NSRC-1:0] visible_o,
    output logic [NSRC-1:0] pend_o,
    output logic            irq_o
);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] clr;

    assign visible_o = pend_q & ~mask_i;
    assign clr       = rd_clr_i ? visible_o : '0;
    assign irq_o     = |visible_o;
    assign pend_o    = pend_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) pend_q <= '0;
        else       pend_q <= (pend_q & ~clr) | set_i;
    end

endmodule

// File: rtl/seqwdt_top.sv
module seqwdt_top
    import seqwdt_pkg::*;
#(
    parameter int CLK_KHZ   = 100000,
    parameter int PERIOD_MS = 128,
    parameter int NSRC      = 4
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            reg_wr_i,
    input  logic            reg_rd_i,
    input  logic [AW-1:0]   reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    input  logic [NSRC-2:0] evt_i,
    output logic            irq_o,
    output logic            wdt_rst_o
);

    reg_sel_e        sel;
    ctrl_t           ctrl_q;
    ctrl_t           wr_ctrl;
    logic [DW-1:0]   mask_q;
    logic [DW-1:0]   rdata_q;
    logic [DW-1:0]   rd_mux;
    logic            ctrl_wr;
    logic            mask_wr;
    logic            stat_rd;
    logic            armed;
    logic            restart;
    logic            fire;
    logic [NSRC-1:0] visible;
    logic [NSRC-1:0] pend;

    assign sel     = reg_sel_e'(reg_addr_i);
    assign wr_ctrl = ctrl_t'(reg_wdata_i);
    assign ctrl_wr = reg_wr_i && (sel == REG_CTRL);
    assign mask_wr = reg_wr_i && (sel == REG_MASK);
    assign stat_rd = reg_rd_i && (sel == REG_STAT);

    seqwdt_kick u_kick (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .armed_i   (armed),
        .ctrl_wr_i (ctrl_wr),
        .kick_a_i  (wr_ctrl.kick_a),
        .kick_b_i  (wr_ctrl.kick_b),
        .restart_o (restart)
    );

    seqwdt_timer #(.DIV(CLK_KHZ), .PERIOD(PERIOD_MS)) u_timer (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .arm_req_i    (ctrl_wr && (wr_ctrl.mode == MODE_WDT)),
        .disarm_req_i (ctrl_wr && (wr_ctrl.mode != MODE_WDT)),
        .restart_i    (restart),
        .armed_o      (armed),
        .fire_o       (fire),
        .pulse_o      (wdt_rst_o)
    );

    seqwdt_irq #(.NSRC(NSRC)) u_irq (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .set_i     ({evt_i, fire}),
        .mask_i    (mask_q[NSRC-1:0]),
        .rd_clr_i  (stat_rd),
        .visible_o (visible),
        .pend_o    (pend),
        .irq_o     (irq_o)
    );

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            REG_CTRL: rd_mux = ctrl_q;
            REG_STAT: rd_mux[NSRC-1:0] = visible;
            REG_MASK: rd_mux = mask_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q  <= '0;
            mask_q  <= '1;
            rdata_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= wr_ctrl;
            if (mask_wr) mask_q <= reg_wdata_i;
            if (reg_rd_i) rdata_q <= rd_mux;
        end
    end

    assign reg_rdata_o = rdata_q;

endmodule

// File: rtl/seqwdt_chk.sv
module seqwdt_chk #(
    parameter int NSRC = 4
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            reg_rd_i,
    input logic [1:0]      reg_addr_i,
    input logic [7:0]      reg_rdata_o,
    input logic            wdt_rst_o,
    input logic            armed,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] mask
);

    // R6: pulse is a single clock wide
    p_pulse_one_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |=> !wdt_rst_o);

    // R6: expiry leaves the timer disarmed
    p_disarm_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |-> !armed);

    // R3: overflow status is recorded together with the pulse
    p_ovf_set_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |-> pend[0]);

    // R2: a disarmed timer cannot produce a pulse next cycle
    p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !armed |=> !wdt_rst_o);

    // R7: masked bits never appear in status read data
    p_mask_hides_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_rd_i && reg_addr_i == 2'd1) |=> ((reg_rdata_o[NSRC-1:0] & $past(mask)) == '0));

    // R8: masked pending bits stay latched
    p_pending_kept_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((pend & $past(pend & mask)) == $past(pend & mask)));

    // R10: unused address reads zero one cycle later
    p_unused_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_rd_i && reg_addr_i == 2'd3) |=> (reg_rdata_o == 8'h00));

endmodule

bind seqwdt_top seqwdt_chk #(.NSRC(NSRC)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .wdt_rst_o   (wdt_rst_o),
    .armed       (armed),
    .pend        (pend),
    .mask        (mask_q[NSRC-1:0])
);

// File: tb/sim_seqwdt_top.sv
module sim_seqwdt_top;

    localparam int KHZ  = 3;
    localparam int PMS  = 10;
    localparam int N    = KHZ * PMS;
    localparam int NSRC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] evt = '0;
    logic       irq;
    logic       wrst;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int pulses = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wrst) pulses <= pulses + 1;
    end

    seqwdt_top #(.CLK_KHZ(KHZ), .PERIOD_MS(PMS), .NSRC(NSRC)) u0 (
        .clk_i(clk), .rst_i(rst), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .evt_i(evt), .irq_o(irq), .wdt_rst_o(wrst)
    );

    typedef struct packed {
        logic [2:0] evt;
        logic [7:0] mask;
        logic       irq;
        logic [7:0] rd;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'b001, 8'hFF, 1'b0, 8'h00},
        '{3'b000, 8'hF0, 1'b1, 8'h02},
        '{3'b110, 8'hF7, 1'b1, 8'h08},
        '{3'b000, 8'hFB, 1'b1, 8'h04},
        '{3'b011, 8'h00, 1'b1, 8'h06},
        '{3'b000, 8'h00, 1'b0, 8'h00}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // expiry due N edges after the edge counted by t_ref
    task automatic expect_expiry(input string tag, input int t_ref);
        int p0;
        p0 = pulses;
        wait_to(t_ref + N - 1);
        check({tag, " no early pulse"}, int'(wrst), 0);
        check({tag, " pulse count before expiry"}, pulses, p0);
        wait_to(t_ref + N);
        check({tag, " pulse at N"}, int'(wrst), 1);
        wait_to(t_ref + N + 1);
        check({tag, " R6 pulse one cycle"}, int'(wrst), 0);
    endtask

    initial begin
        logic [7:0] d;
        int t;
        int p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", int'(irq), 0);
        check("R1 rst pulse", int'(wrst), 0);
        rd_reg(2'd0, d); check("R1 ctrl", d, 8'h00);
        rd_reg(2'd2, d); check("R1 mask", d, 8'hFF);
        rd_reg(2'd1, d); check("R1 status", d, 8'h00);

        // R7 R8 R9 vector table
        foreach (VEC[i]) begin
            wr_reg(2'd2, VEC[i].mask);
            @(negedge clk); evt = VEC[i].evt;
            @(negedge clk); evt = '0;
            check($sformatf("R7 R8 vec%0d irq", i), int'(irq), int'(VEC[i].irq));
            rd_reg(2'd1, d);
            check($sformatf("R9 vec%0d status read", i), d, VEC[i].rd);
        end

        // R10 unused address and mask readback
        rd_reg(2'd3, d); check("R10 addr3 reads zero", d, 8'h00);
        rd_reg(2'd2, d); check("R10 mask readback", d, 8'h00);

        // R2 mode 10 does not arm
        p0 = pulses;
        wr_reg(2'd0, 8'h02);
        t = cyc; wait_to(t + 2 * N);
        check("R2 no pulse without arming", pulses, p0);

        // R3 plain expiry, overflow bit
        wr_reg(2'd0, 8'h03); t = cyc;
        expect_expiry("R3 expiry", t);
        check("R3 irq after overflow", int'(irq), 1);
        rd_reg(2'd1, d); check("R3 R9 overflow status", d, 8'h01);
        check("R9 irq after clear", int'(irq), 0);
        p0 = pulses; t = cyc; wait_to(t + 3 * N);
        check("R6 stays disarmed", pulses, p0);

        // R4 kick with a foreign access between the steps
        wr_reg(2'd0, 8'h03); t = cyc;
        wait_to(t + 20);
        wr_reg(2'd0, 8'h07);
        wr_reg(2'd2, 8'h00);
        rd_reg(2'd2, d);
        wr_reg(2'd0, 8'h0B); t = cyc;
        expect_expiry("R4 restart", t);
        rd_reg(2'd1, d);

        // R4 two kicks in a row keep it alive
        wr_reg(2'd0, 8'h03); t = cyc;
        wait_to(t + 18);
        wr_reg(2'd0, 8'h07); wr_reg(2'd0, 8'h0B); t = cyc;
        wait_to(t + 18);
        wr_reg(2'd0, 8'h07); wr_reg(2'd0, 8'h0B); t = cyc;
        expect_expiry("R4 repeated kick", t);
        rd_reg(2'd1, d);

        // R5 second step alone
        wr_reg(2'd0, 8'h03); t = cyc;
        wait_to(t + 5);
        wr_reg(2'd0, 8'h0B);
        expect_expiry("R5 second step alone", t);
        rd_reg(2'd1, d);

        // R5 foreign control value between the steps
        wr_reg(2'd0, 8'h03); t = cyc;
        wait_to(t + 4);
        wr_reg(2'd0, 8'h07);
        wr_reg(2'd0, 8'h03);
        wr_reg(2'd0, 8'h0B);
        expect_expiry("R5 broken sequence", t);
        rd_reg(2'd1, d);

        // R6 disarm by mode write
        wr_reg(2'd0, 8'h03); t = cyc;
        wait_to(t + 5);
        wr_reg(2'd0, 8'h00);
        p0 = pulses; t = cyc; wait_to(t + 2 * N);
        check("R6 disarm by mode 00", pulses, p0);

        // R8 masked overflow stays pending
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd0, 8'h03); t = cyc;
        expect_expiry("R8 masked expiry", t);
        check("R8 irq masked", int'(irq), 0);
        rd_reg(2'd1, d); check("R8 masked read zero", d, 8'h00);
        wr_reg(2'd2, 8'hFE);
        check("R8 irq after unmask", int'(irq), 1);
        rd_reg(2'd1, d); check("R8 pending visible", d, 8'h01);
        rd_reg(2'd1, d); check("R9 cleared after read", d, 8'h00);
        check("R9 irq low", int'(irq), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R-all actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule